// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition-Flag Register

This block is a 64-bit arithmetic/logic unit for a simple processor's execute stage. A 4-bit function code selects one of four operations on two operands: add, subtract, bitwise AND or bitwise XOR. The result is combinational and appears in the same cycle as the operands.

Three condition flags are derived from each result: zero, sign and signed overflow. They are captured in a clocked register only on rising edges where the flag-load enable is high. When the enable is low, the register keeps the flags of the last operation that was allowed to update them. A later stage can then test the stored flags while the ALU is busy with unrelated arithmetic.

Top module: `alu_cc_unit`

## Requirements
- R1: Function code 0 gives result = opB + opA, modulo 2^64.
- R2: Function code 1 gives result = opB - opA, modulo 2^64.
- R3: Function code 2 gives opA AND opB, and function code 3 gives opA XOR opB.
- R4: Function codes 4 to 15 give a result of zero.
- R5: While rstN is low, the stored flags are zeroFlag=1, signFlag=0 and ovfFlag=0.
- R6: On a rising edge with setCc high, zeroFlag becomes 1 exactly when the result is zero, and signFlag becomes result bit 63.
- R7: On a rising edge with setCc high, ovfFlag becomes the signed overflow of the operation. For add, it is 1 when both operands have the same sign and the result's sign differs from it. For subtract, it is 1 when the operand signs differ and the result's sign differs from opB's sign. For codes 2 to 15 it is 0.
- R8: On a rising edge with setCc low, all three stored flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| funcCode | input | 4 | Operation select |
| opA | input | 64 | First operand (subtrahend for subtract) |
| opB | input | 64 | Second operand (minuend for subtract) |
| setCc | input | 1 | Flag-register load enable |
| result | output | 64 | Combinational ALU result |
| zeroFlag | output | 1 | Stored zero flag |
| signFlag | output | 1 | Stored sign flag |
| ovfFlag | output | 1 | Stored signed-overflow flag |

## Verification
The bench targets the overflow edges for add and subtract: the largest positive value plus one, the most negative value minus one, and subtracting a value from itself. A design with the operand order swapped in subtract, or with overflow computed from the unmodified operand signs, would get the wrong sign or overflow flag in these cases. Unused function codes are driven with all-ones operands, so a design that falls through to some operation would give a nonzero result. The bench also changes the operands while setCc is low, so a register that loads on every edge would change its flags.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_ZERO} aluOpE;

  typedef struct packed {
    aluOpE op;
    logic  loadFlags;
  } ctrlStrobesT;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } ccFlagsT;

  localparam ccFlagsT CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_cc_pkg::*;
(
  input  logic [3:0]  funcCode,
  input  logic        setCc,
  output ctrlStrobesT strobes
);
  always_comb begin
    strobes.loadFlags = setCc;
    case (funcCode)
      4'd0:    strobes.op = OP_ADD;
      4'd1:    strobes.op = OP_SUB;
      4'd2:    strobes.op = OP_AND;
      4'd3:    strobes.op = OP_XOR;
      default: strobes.op = OP_ZERO;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobesT      strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output ccFlagsT          flags
);
  localparam int MSB = WIDTH - 1;

  logic             isSub;
  logic [WIDTH-1:0] aEff;
  logic [WIDTH-1:0] sum;
  logic             ovfArith;
  logic             ovfSel;
  ccFlagsT          flagsNext;

  // Shared adder: subtract is opB + ~opA + 1.
  always_comb begin
    isSub    = (strobes.op == OP_SUB);
    aEff     = isSub ? ~opA : opA;
    sum      = opB + aEff + WIDTH'(isSub);
    ovfArith = (aEff[MSB] == opB[MSB]) && (sum[MSB] != opB[MSB]);
  end

  always_comb begin
    case (strobes.op)
      OP_ADD, OP_SUB: begin result = sum;         ovfSel = ovfArith; end
      OP_AND:         begin result = opA & opB;   ovfSel = 1'b0;     end
      OP_XOR:         begin result = opA ^ opB;   ovfSel = 1'b0;     end
      default:        begin result = '0;          ovfSel = 1'b0;     end
    endcase
    flagsNext.zf = ~|result;
    flagsNext.sf = result[MSB];
    flagsNext.of = ovfSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flags <= CC_RESET;
    else if (strobes.loadFlags) flags <= flagsNext;
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       funcCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             setCc,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             signFlag,
  output logic             ovfFlag
);
  ctrlStrobesT strobes;
  ccFlagsT     flags;

  alu_ctrl u_ctrl (
    .funcCode (funcCode),
    .setCc    (setCc),
    .strobes  (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .flags   (flags)
  );

  assign zeroFlag = flags.zf;
  assign signFlag = flags.sf;
  assign ovfFlag  = flags.of;
endmodule

// File: rtl/alu_cc_checker.sv
module alu_cc_checker #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       funcCode,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             setCc,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             signFlag,
  input logic             ovfFlag
);
  // R2
  sub_inverse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcCode == 4'd1) |-> (result + opA == opB));

  // R4
  unused_code_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcCode > 4'd3) |-> (result == '0));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    setCc |=> (zeroFlag == ($past(result) == '0)));

  // R6
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    setCc |=> (signFlag == $past(result[WIDTH-1])));

  // R7
  logic_no_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setCc && funcCode > 4'd1) |=> !ovfFlag);

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !setCc |=> ($stable(zeroFlag) && $stable(signFlag) && $stable(ovfFlag)));
endmodule

bind alu_cc_unit alu_cc_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu_cc_unit.sv
module tb_alu_cc_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  funcCode = '0;
  logic [63:0] opA = '0, opB = '0;
  logic        setCc = 1'b0;
  logic [63:0] result;
  logic        zeroFlag, signFlag, ovfFlag;

  int  nTests = 0, nFails = 0;
  bit  done = 0;
  bit  mZ = 1, mS = 0, mO = 0;

  always #2 clk = ~clk;

  alu_cc_unit dut (.*);

  function automatic string reqFor(input logic [3:0] f);
    if (f == 0) return "R1";
    if (f == 1) return "R2";
    if (f < 4)  return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] f, input logic [63:0] a, input logic [63:0] b, input bit set);
    longint sa, sb, r;
    bit ov;
    @(negedge clk);
    funcCode = f; opA = a; opB = b; setCc = set;
    sa = a; sb = b; ov = 0;
    case (f)
      0: begin r = sb + sa; ov = ((sa < 0) == (sb < 0)) && ((r < 0) != (sa < 0)); end
      1: begin r = sb - sa; ov = ((sa < 0) != (sb < 0)) && ((r < 0) != (sb < 0)); end
      2: r = sa & sb;
      3: r = sa ^ sb;
      default: r = 0;
    endcase
    #1;
    check(reqFor(f), result, r);
    @(posedge clk);
    if (set) begin mZ = (r == 0); mS = (r < 0); mO = ov; end
    #1;
    check(set ? "R6" : "R8", {zeroFlag, signFlag}, {mZ, mS});
    check(set ? "R7" : "R8", ovfFlag, mO);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    setCc = 1'b1; opA = '1; funcCode = 4'd3;
    repeat (3) @(posedge clk);
    #1;
    check("R5", {zeroFlag, signFlag, ovfFlag}, 3'b100);
    @(negedge clk); rstN = 1'b1;

    step(0, 64'd1, 64'h7FFF_FFFF_FFFF_FFFF, 1);   // R1 overflow to negative
    step(0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1); // R1 wraps to zero
    step(1, 64'd1, 64'h8000_0000_0000_0000, 1);   // R2 min - 1 overflows
    step(1, 64'h1234, 64'h1234, 1);               // R2 zero result
    step(1, 64'd5, 64'd3, 1);                     // R2 negative, no overflow
    step(2, 64'hF0F0_0000_FFFF_1234, 64'hFFFF_0F0F_8000_00FF, 1); // R3 and
    step(3, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 1); // R3 xor sign
    step(7, '1, '1, 1);                           // R4
    step(15, '1, '1, 1);                          // R4
    step(0, 64'd1, 64'h7FFF_FFFF_FFFF_FFFF, 1);   // set OF again
    step(1, 64'd9, 64'd9, 0);                     // R8 hold
    step(3, 64'd1, 64'd2, 0);                     // R8 hold
    step(4, 64'd1, 64'd2, 1);                     // R4 zero, flags reload
    for (int i = 0; i < 400; i++)
      step(4'($urandom_range(0, 15) < 12 ? $urandom_range(0, 3) : $urandom_range(4, 15)),
           {$urandom, $urandom}, {$urandom, $urandom}, ($urandom_range(0, 3) != 0));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule